// File: doc/BRIEF.md
# Windowed Up-Counter with Start and Stop Bounds

This block is a synchronous binary up-counter whose sequence is confined to a window set by two inputs: a first value and a last value. When the count reaches the last value and counting is enabled, the next clock reloads the first value rather than letting the counter roll over the full modulus. A first value of zero gives an end-bounded counter, and a last value of all ones gives a start-bounded counter. Setting both gives a counter that cycles between any two values.

Around the window logic the counter has the usual controls. A synchronous clear forces zero. A synchronous parallel load forces any value. An enable gates counting. A carry flag is high while the count is all ones. The carry flag is not gated by the enable, so a following stage can form its own enable as the AND of the shared enable and this flag. Two such stages then count as one wider binary counter. A synchronous active-low reset puts the count at zero.

Top module: `window_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `count` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst_n` high, `clr` high at an edge makes `count` 0. It takes priority over `ld` and `en`.
- R3: With `clr` low, `ld` high at an edge makes `count` equal to `ld_data`. It takes priority over `en` and over the window reload.
- R4: With `clr`, `ld` and `en` all low, `count` keeps its value across the edge.
- R5: With `en` high, and `win_stop` not below `win_start`, a `count` equal to `win_stop` is replaced by `win_start` at the edge. This includes the case where the two bounds are equal.
- R6: With `en` high, `win_stop` not below `win_start`, and `count` different from `win_stop`, `count` increases by one modulo 2^WIDTH. After 1111 it goes to 0000 when that step is needed to reach `win_stop`.
- R7: With `en` high and `win_stop` below `win_start` (unsigned), every enabled edge loads `win_start`, whatever the current count.
- R8: `carry_out` is high in the same cycle that `count` is all ones (1111), and low otherwise, independent of `en`. Two stages with the upper enable equal to `en` AND lower `carry_out` form one 2*WIDTH-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear to zero |
| ld | input | 1 | Synchronous parallel load |
| en | input | 1 | Count enable |
| ld_data | input | WIDTH | Parallel load value |
| win_start | input | WIDTH | First value of the counting window |
| win_stop | input | WIDTH | Last value of the counting window |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High while count is all ones |

## Verification
The count is the only state, so any corruption of it shows on `count` one clock after the edge that caused it. A wrong priority choice or a wrong comparator result shows at that same point. A carry chain that breaks the all-ones detection shows on `carry_out` in the same cycle, without waiting for an edge. A fault that only affects the wrap from 1111 or the inverted window shows only when those states are driven, so the stimulus walks through both of them. A fault in the carry path also shows in a cascaded pair: the upper stage skips or repeats a step once every 2^WIDTH cycles.

// File: rtl/window_counter_pkg.sv
// Shared types for the windowed counter.
// Assumes: nothing beyond IEEE 1800-2017.
package window_counter_pkg;

    // Next-state source chosen by the priority selector.
    typedef enum logic [2:0] {
        WC_ZERO   = 3'd0,
        WC_LOAD   = 3'd1,
        WC_RELOAD = 3'd2,
        WC_STEP   = 3'd3,
        WC_HOLD   = 3'd4
    } wc_action_e;

endpackage

// File: rtl/wc_incrementer.sv
// Ripple incrementer built from a generated half-adder chain.
// The chain's final carry doubles as the all-ones flag.
// Assumes: WIDTH >= 1.
module wc_incrementer #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value_in,
    output logic [WIDTH-1:0] value_plus_one,
    output logic             all_ones
);
    logic [WIDTH:0] chain;

    // Carry into bit 0 is the constant one of the increment.
    assign chain[0] = 1'b1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_half_add
        // One half adder per bit: sum and carry toward the next bit.
        assign value_plus_one[b] = value_in[b] ^ chain[b];
        assign chain[b+1]        = value_in[b] & chain[b];
    end

    // The carry leaves the top bit only when every bit was one.
    assign all_ones = chain[WIDTH];
endmodule

// File: rtl/wc_window_cmp.sv
// Window comparator: decides whether an enabled edge must reload the
// first value, either because the last value is reached or because the
// window is inverted (last below first).
// Assumes: bounds are unsigned.
module wc_window_cmp #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] first_val,
    input  logic [WIDTH-1:0] last_val,
    output logic             reload_req
);
    logic at_last;
    logic inverted;

    // Compare current count with the bounds.
    always_comb begin
        at_last    = (cur == last_val);
        inverted   = (last_val < first_val);
        reload_req = at_last | inverted;
    end
endmodule

// File: rtl/wc_action_sel.sv
// Priority selector: clear, then load, then window reload, then step.
// Assumes: reset is handled by the state register, not here.
module wc_action_sel
    import window_counter_pkg::*;
(
    input  logic       clr,
    input  logic       ld,
    input  logic       en,
    input  logic       reload_req,
    output wc_action_e action
);
    // Fixed-priority choice of the next-state source.
    always_comb begin
        if (clr)             action = WC_ZERO;
        else if (ld)         action = WC_LOAD;
        else if (!en)        action = WC_HOLD;
        else if (reload_req) action = WC_RELOAD;
        else                 action = WC_STEP;
    end
endmodule

// File: rtl/window_counter.sv
// Windowed up-counter top. It holds the count register and routes the
// chosen next value into it. The carry flag is raised on all ones so
// that stages can be cascaded.
// Assumes: single clock; rst_n is synchronous and active low.
module window_counter
    import window_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic             en,
    input  logic [WIDTH-1:0] ld_data,
    input  logic [WIDTH-1:0] win_start,
    input  logic [WIDTH-1:0] win_stop,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] ZERO_VAL = '0;

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_inc;
    logic [WIDTH-1:0] cnt_d;
    logic             reload_req;
    logic             full_flag;
    wc_action_e       action;

    wc_incrementer #(.WIDTH(WIDTH)) u_inc (
        .value_in       (cnt_q),
        .value_plus_one (cnt_inc),
        .all_ones       (full_flag)
    );

    wc_window_cmp #(.WIDTH(WIDTH)) u_cmp (
        .cur        (cnt_q),
        .first_val  (win_start),
        .last_val   (win_stop),
        .reload_req (reload_req)
    );

    wc_action_sel u_sel (
        .clr        (clr),
        .ld         (ld),
        .en         (en),
        .reload_req (reload_req),
        .action     (action)
    );

    // Map the chosen action onto a next-state value.
    always_comb begin
        unique case (action)
            WC_ZERO:   cnt_d = ZERO_VAL;
            WC_LOAD:   cnt_d = ld_data;
            WC_RELOAD: cnt_d = win_start;
            WC_STEP:   cnt_d = cnt_inc;
            default:   cnt_d = cnt_q;
        endcase
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= ZERO_VAL;
        else        cnt_q <= cnt_d;
    end

    assign count     = cnt_q;
    assign carry_out = full_flag;
endmodule

// File: rtl/window_counter_checker.sv
// Property checker for the windowed counter, attached by bind.
// Assumes: it observes the top-level ports only.
module window_counter_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             ld,
    input logic             en,
    input logic [WIDTH-1:0] ld_data,
    input logic [WIDTH-1:0] win_start,
    input logic [WIDTH-1:0] win_stop,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);
    logic armed_q;
    logic rst_prev_q;

    // Remember whether the last edge saw reset asserted.
    always_ff @(posedge clk) begin
        armed_q    <= 1'b1;
        rst_prev_q <= !rst_n;
    end

    // R1: the count reads zero after an edge with reset low.
    always @(negedge clk) begin
        if (armed_q && rst_prev_q)
            assert_reset_zero_R1: assert (count == '0)
                else $error("R1 count %0d after reset", count);
    end

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (count == $past(ld_data)));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && !en) |=> $stable(count));

    assert_reload_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && (win_stop >= win_start) && (count == win_stop))
        |=> (count == $past(win_start)));

    assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && (win_stop >= win_start) && (count != win_stop))
        |=> (count == WIDTH'($past(count) + 1'b1)));

    assert_inverted_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && (win_stop < win_start))
        |=> (count == $past(win_start)));

    assert_carry_rises_from_below_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld && en && (win_stop == '1) && (win_start == '0)
         && (count == {{(WIDTH-1){1'b1}}, 1'b0}))
        |=> carry_out);
endmodule

bind window_counter window_counter_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .ld        (ld),
    .en        (en),
    .ld_data   (ld_data),
    .win_start (win_start),
    .win_stop  (win_stop),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/window_counter_bench.sv
module window_counter_bench;
    localparam int W = 4;

    typedef struct packed {
        logic         clr;
        logic         ld;
        logic         en;
        logic [W-1:0] data;
        logic [W-1:0] start;
        logic [W-1:0] stop;
        logic [W-1:0] exp_cnt;
        logic         exp_c;
        logic [3:0]   req;
    } vec_t;

    // Each row: clr ld en data start stop -> expected count, carry; requirement.
    localparam vec_t TABLE [20] = '{
        '{1'b0,1'b1,1'b1,4'd6 ,4'd3,4'd9 ,4'd6 ,1'b0,4'd3}, // R3 load wins over en
        '{1'b0,1'b0,1'b1,4'd0 ,4'd3,4'd9 ,4'd7 ,1'b0,4'd6}, // R6
        '{1'b0,1'b0,1'b1,4'd0 ,4'd3,4'd9 ,4'd8 ,1'b0,4'd6}, // R6
        '{1'b0,1'b0,1'b1,4'd0 ,4'd3,4'd9 ,4'd9 ,1'b0,4'd6}, // R6
        '{1'b0,1'b0,1'b1,4'd0 ,4'd3,4'd9 ,4'd3 ,1'b0,4'd5}, // R5 reload at stop
        '{1'b0,1'b0,1'b0,4'd0 ,4'd3,4'd9 ,4'd3 ,1'b0,4'd4}, // R4 hold
        '{1'b1,1'b1,1'b1,4'd5 ,4'd3,4'd9 ,4'd0 ,1'b0,4'd2}, // R2 clear wins
        '{1'b0,1'b1,1'b1,4'd14,4'd3,4'd9 ,4'd14,1'b0,4'd3}, // R3
        '{1'b0,1'b0,1'b1,4'd0 ,4'd0,4'd15,4'd15,1'b1,4'd8}, // R8 carry on 1111
        '{1'b0,1'b0,1'b0,4'd0 ,4'd0,4'd15,4'd15,1'b1,4'd8}, // R8 carry with en low
        '{1'b0,1'b0,1'b1,4'd0 ,4'd0,4'd13,4'd0 ,1'b0,4'd6}, // R6 wrap 1111->0000
        '{1'b0,1'b0,1'b1,4'd0 ,4'd0,4'd0 ,4'd0 ,1'b0,4'd5}, // R5 start equals stop
        '{1'b0,1'b0,1'b1,4'd0 ,4'd9,4'd4 ,4'd9 ,1'b0,4'd7}, // R7 inverted window
        '{1'b0,1'b0,1'b1,4'd0 ,4'd9,4'd4 ,4'd9 ,1'b0,4'd7}, // R7 stays at start
        '{1'b0,1'b1,1'b1,4'd2 ,4'd9,4'd4 ,4'd2 ,1'b0,4'd3}, // R3 load beats reload
        '{1'b0,1'b0,1'b1,4'd0 ,4'd9,4'd4 ,4'd9 ,1'b0,4'd7}, // R7
        '{1'b0,1'b0,1'b1,4'd0 ,4'd6,4'd15,4'd10,1'b0,4'd6}, // R6
        '{1'b0,1'b1,1'b0,4'd15,4'd6,4'd15,4'd15,1'b1,4'd3}, // R3 load with en low
        '{1'b0,1'b0,1'b1,4'd0 ,4'd6,4'd15,4'd6 ,1'b0,4'd5}, // R5 start offset
        '{1'b1,1'b0,1'b0,4'd0 ,4'd6,4'd15,4'd0 ,1'b0,4'd2}  // R2 clear, en low
    };

    logic         clk = 1'b0;
    logic         rst_n, clr, ld, en;
    logic [W-1:0] ld_data, win_start, win_stop;
    logic [W-1:0] count, count_hi;
    logic         carry_out, carry_hi;
    logic         en_hi;
    logic         ld_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    assign en_hi = en & carry_out;
    assign ld_hi = 1'b0;

    window_counter #(.WIDTH(W)) u_window_counter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .en(en),
        .ld_data(ld_data), .win_start(win_start), .win_stop(win_stop),
        .count(count), .carry_out(carry_out)
    );

    window_counter #(.WIDTH(W)) u_window_counter_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld_hi), .en(en_hi),
        .ld_data(ld_data), .win_start(win_start), .win_stop(win_stop),
        .count(count_hi), .carry_out(carry_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; ld = 1'b0; en = 1'b0;
        ld_data = '0; win_start = '0; win_stop = '0;
        @(negedge clk);
        ld = 1'b1; ld_data = 4'd11; en = 1'b1;
        tick(); tick();
        // R1: reset state of both stages, even with load and enable high.
        check("R1 reset count", int'(count), 0);
        check("R1 reset carry", int'(carry_out), 0);
        check("R1 reset upper stage", int'(count_hi), 0);
        rst_n = 1'b1; ld = 1'b0; en = 1'b0;

        // Table walk.
        foreach (TABLE[i]) begin
            clr = TABLE[i].clr; ld = TABLE[i].ld; en = TABLE[i].en;
            ld_data = TABLE[i].data; win_start = TABLE[i].start; win_stop = TABLE[i].stop;
            tick();
            check($sformatf("R%0d row %0d count", TABLE[i].req, i), int'(count), int'(TABLE[i].exp_cnt));
            check($sformatf("R8 row %0d carry", i), int'(carry_out), int'(TABLE[i].exp_c));
        end

        // R1: reset in the middle of a run beats load.
        clr = 1'b0; ld = 1'b1; en = 1'b0; ld_data = 4'd12;
        tick();
        check("R3 preload before reset", int'(count), 12);
        rst_n = 1'b0; ld_data = 4'd7; en = 1'b1;
        tick();
        check("R1 mid-run reset", int'(count), 0);
        rst_n = 1'b1; ld = 1'b0; en = 1'b0;

        // R8: two stages cascaded through carry as one 8-bit counter.
        clr = 1'b1; win_start = 4'd0; win_stop = 4'd15;
        tick();
        clr = 1'b0; en = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            tick();
            if (k == 15) check("R8 cascade carry at 15", int'(carry_out), 1);
            if (k == 16 || k == 40)
                check($sformatf("R8 cascade value after %0d", k),
                      int'({count_hi, count}), k);
        end
        en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule